// File: doc/BRIEF.md
# Code-to-Temperature Converter

This block turns a raw thermal-sensor reading into a signed temperature in millidegrees Celsius. The reading is first cut down to the converter's data width. A binary search over a fixed calibration table then finds the pair of neighbouring entries that bracket it, and the block interpolates linearly between their temperatures. The table is fixed when the block is built. It can be ordered with codes rising or falling as temperature rises, and the direction is chosen by parameter.

A reading is handed over with a valid/ready handshake. The block works on one reading at a time. The result is a temperature together with an invalid flag, presented in one output handshake. Readings that the table cannot place, such as a code below the lowest legal code or a code that no entry pair brackets, come back with the flag set and a zero temperature. The interpolation uses an unsigned division that truncates and runs over several cycles.

Top module: `code_temp_conv`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Only the low MASK_BITS bits of `in_code` are used (12 by default, 10 as the alternative); the upper bits are treated as zero everywhere.
- R3: The table has LEN=36 entries. Temperatures: T[0]=-40000, T[i]=-40000+5000*(i-1) for 1<=i<=34, T[35]=125000. Rising mode codes: C[0]=0, C[i]=BASE+STEP*(i-1)+floor((i-1)/3) for 1<=i<=34, C[35]=2^MASK_BITS-1. Falling mode codes: C[0]=2^MASK_BITS-1, C[i]=BASE-(STEP*(i-1)+floor((i-1)/3)) for 1<=i<=34, C[35]=C[34]-STEP.
- R4: In rising mode the block finds m with C[m-1] < code <= C[m] and returns T[m-1] + floor((T[m]-T[m-1])*(code-C[m-1])/(C[m]-C[m-1])), with `out_invalid`=0.
- R5: In falling mode the block finds m with C[m] <= code < C[m-1] and returns T[m-1] + floor((T[m]-T[m-1])*(C[m-1]-code)/(C[m-1]-C[m])), with `out_invalid`=0.
- R6: In rising mode a masked code below C[1] returns `out_invalid`=1 and `out_temp`=0.
- R7: In falling mode a masked code below C[35] returns `out_invalid`=1 and `out_temp`=0.
- R8: A code that passes the range check but that no entry pair brackets (in falling mode, the code 2^MASK_BITS-1) returns `out_invalid`=1 and `out_temp`=0.
- R9: A code that equals a table code C[i] with 1<=i<=34 returns exactly T[i]. Codes in the end band next to the padding entry (rising: above C[34]; falling: from C[35] up to below C[34]) return 125000.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_temp` and `out_invalid` hold their values.
- R11: `in_ready` is 0 from the edge that accepts a reading until the edge that consumes its result. `in_valid` and `in_code` have no effect during that time, and each accepted reading yields exactly one result.
- R12: `out_valid` rises no later than clog2(LEN)+DIV_W+2 = 40 clock edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Reading offered |
| in_ready | output | 1 | Block idle and able to take a reading |
| in_code | input | CODE_W (16) | Raw sensor code |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_temp | output | 32 | Signed temperature in millidegrees |
| out_invalid | output | 1 | Reading could not be converted |

## Verification
A rejected reading is due one edge after acceptance. A converted reading is due once the search hits, which takes one to six edges after the range-check edge, plus DIV_W divider edges and one edge to write the result. In every case it is due by edge 40. The bench drives and samples on falling edges. It counts the edges from acceptance to the first `out_valid`, checks that count against the bound, and only then compares the values. It then holds `out_ready` low for two more cycles before consuming the result, and checks that the block returns to idle one edge later.

// File: rtl/code_temp_conv_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the code-to-temperature converter.
// Holds the controller state type and the constant functions that build
// the calibration table at elaboration time.
package code_temp_conv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SEARCH,
        ST_DIV,
        ST_DONE
    } conv_state_t;

    // Calibration code of entry i; rising or falling order, padded at both ends.
    function automatic int unsigned tab_code(int i, int len, bit rising,
                                             int base, int step, int unsigned top);
        int k;
        k = i - 1;
        if (rising) begin
            if (i == 0)       return 0;
            if (i == len - 1) return top;
            return base + step * k + k / 3;
        end
        if (i == 0)       return top;
        if (i == len - 1) return base - (step * (k - 1) + (k - 1) / 3) - step;
        return base - (step * k + k / 3);
    endfunction

    // Temperature of entry i in millidegrees; end entries repeat their neighbours.
    function automatic int tab_temp(int i, int len, int tmin, int tstep);
        if (i == 0)       return tmin;
        if (i == len - 1) return tmin + tstep * (len - 3);
        return tmin + tstep * (i - 1);
    endfunction

endpackage

// File: rtl/code_temp_table.sv
`timescale 1ns/1ps
// Calibration ROM for the converter.
// Returns the entry at idx and the entry just below it (idx-1) in one cycle,
// plus the lowest legal code for the range check.
// Assumes idx < LEN; index 0 reads entry 0 on both ports.
module code_temp_table #(
    parameter int CODE_W    = 16,
    parameter int MASK_BITS = 12,
    parameter bit RISING    = 1'b1,
    parameter int LEN       = 36,
    parameter int BASE_CODE = 300,
    parameter int STEP_CODE = 9,
    parameter int TEMP_MIN  = -40000,
    parameter int TEMP_STEP = 5000,
    localparam int SEL_W    = $clog2(LEN)
) (
    input  logic [SEL_W-1:0]         idx,
    output logic [CODE_W-1:0]        code_hi,
    output logic [CODE_W-1:0]        code_lo,
    output logic signed [31:0]       temp_hi,
    output logic signed [31:0]       temp_lo,
    output logic [CODE_W-1:0]        floor_code
);
    localparam int unsigned TOP_CODE = (1 << MASK_BITS) - 1;

    logic [CODE_W-1:0]  code_rom [LEN];
    logic signed [31:0] temp_rom [LEN];
    logic [SEL_W-1:0]   lo_idx;

    // Build each entry from the constant functions.
    for (genvar g = 0; g < LEN; g++) begin : g_entry
        localparam int unsigned CV = code_temp_conv_pkg::tab_code(g, LEN, RISING,
                                         BASE_CODE, STEP_CODE, TOP_CODE);
        localparam int TV = code_temp_conv_pkg::tab_temp(g, LEN, TEMP_MIN, TEMP_STEP);
        assign code_rom[g] = CODE_W'(CV);
        assign temp_rom[g] = 32'(TV);
    end

    // Two read ports: the selected entry and its lower neighbour.
    always_comb begin
        lo_idx  = (idx == '0) ? '0 : idx - SEL_W'(1);
        code_hi = code_rom[idx];
        temp_hi = temp_rom[idx];
        code_lo = code_rom[lo_idx];
        temp_lo = temp_rom[lo_idx];
    end

    // Lowest legal code: entry 1 when rising, last entry when falling.
    if (RISING) begin : g_floor_rise
        assign floor_code = code_rom[1];
    end else begin : g_floor_fall
        assign floor_code = code_rom[LEN-1];
    end

endmodule

// File: rtl/code_temp_divu.sv
`timescale 1ns/1ps
// Unsigned restoring divider, one quotient bit per cycle.
// A start pulse loads the operands; after W cycles done pulses once and quo
// holds the truncated quotient. Assumes den != 0 and start only while idle.
module code_temp_divu #(
    parameter int W = 32,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    logic [W-1:0]     rem;
    logic [W-1:0]     dv;
    logic [CNT_W-1:0] cnt;
    logic [W:0]       trial;
    logic             ge;

    // Shift in the next dividend bit and compare with the divisor.
    always_comb begin
        trial = {rem, quo[W-1]};
        ge    = (trial >= {1'b0, dv});
    end

    // Load on start, then one restoring step per cycle until the count ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem  <= '0;
            dv   <= '0;
            quo  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= '0;
                quo  <= num;
                dv   <= den;
                cnt  <= CNT_W'(W);
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= ge ? W'(trial - {1'b0, dv}) : trial[W-1:0];
                quo  <= {quo[W-2:0], ge};
                cnt  <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R12: completion only follows a busy cycle.
    a_r12_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R11: the controller never restarts a division in flight.
    a_r11_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/code_temp_conv.sv
`timescale 1ns/1ps
// Code-to-temperature converter, top level.
// Accepts one masked sensor code, rejects codes below the table floor,
// binary-searches the calibration table for the bracketing entry pair and
// interpolates with a sequential truncating divider. One reading in flight.
// Assumes CODE_W >= MASK_BITS and a strictly monotone table.
module code_temp_conv #(
    parameter int CODE_W    = 16,
    parameter int MASK_BITS = 12,
    parameter bit RISING    = 1'b1,
    parameter int LEN       = 36,
    parameter int BASE_CODE = 300,
    parameter int STEP_CODE = 9,
    parameter int TEMP_MIN  = -40000,
    parameter int TEMP_STEP = 5000,
    parameter int DIV_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CODE_W-1:0]  in_code,
    output logic               out_valid,
    input  logic               out_ready,
    output logic signed [31:0] out_temp,
    output logic               out_invalid
);
    import code_temp_conv_pkg::*;

    localparam int SEL_W   = $clog2(LEN);
    localparam int IDX_W   = SEL_W + 1;
    localparam int LAT_MAX = SEL_W + DIV_W + 2;
    localparam int TEMP_MAX = TEMP_MIN + TEMP_STEP * (LEN - 3);
    localparam logic [CODE_W-1:0] MASK_EXT = CODE_W'((1 << MASK_BITS) - 1);

    conv_state_t        state;
    logic [CODE_W-1:0]  code_q;
    logic [IDX_W-1:0]   low, high, mid;
    logic [IDX_W:0]     span_sum;
    logic [CODE_W-1:0]  code_hi, code_lo, floor_code, dcode, dspan;
    logic signed [31:0] temp_hi, temp_lo, base_temp, tdiff;
    logic               in_range, hit, go_up, reject;
    logic               div_start, div_busy, div_done;
    logic [DIV_W-1:0]   div_num, div_den, div_quo;
    logic [7:0]         lat_cnt;

    code_temp_table #(
        .CODE_W(CODE_W), .MASK_BITS(MASK_BITS), .RISING(RISING), .LEN(LEN),
        .BASE_CODE(BASE_CODE), .STEP_CODE(STEP_CODE),
        .TEMP_MIN(TEMP_MIN), .TEMP_STEP(TEMP_STEP)
    ) u_table (
        .idx(mid[SEL_W-1:0]), .code_hi(code_hi), .code_lo(code_lo),
        .temp_hi(temp_hi), .temp_lo(temp_lo), .floor_code(floor_code)
    );

    code_temp_divu #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quo(div_quo)
    );

    // Search decisions and interpolation operands for the current midpoint.
    always_comb begin
        span_sum = {1'b0, low} + {1'b0, high};
        mid      = span_sum[IDX_W:1];
        in_range = (low <= high);
        reject   = (code_q < floor_code);
        if (RISING) begin
            hit   = (code_q <= code_hi) && (code_q > code_lo);
            go_up = (code_q > code_hi);
            dcode = code_q - code_lo;
            dspan = code_hi - code_lo;
        end else begin
            hit   = (code_q >= code_hi) && (code_q < code_lo);
            go_up = (code_q < code_hi);
            dcode = code_lo - code_q;
            dspan = code_lo - code_hi;
        end
        tdiff     = temp_hi - temp_lo;
        div_num   = DIV_W'($unsigned(tdiff)) * DIV_W'(dcode);
        div_den   = DIV_W'(dspan);
        div_start = (state == ST_SEARCH) && in_range && hit;
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_DONE);
    end

    // Controller: accept, range check, search step, divide, present result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            code_q      <= '0;
            low         <= '0;
            high        <= '0;
            base_temp   <= '0;
            out_temp    <= '0;
            out_invalid <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (in_valid) begin
                    code_q <= in_code & MASK_EXT;
                    low    <= IDX_W'(1);
                    high   <= IDX_W'(LEN - 1);
                    state  <= ST_CHECK;
                end
                ST_CHECK: if (reject) begin
                    out_invalid <= 1'b1;
                    out_temp    <= '0;
                    state       <= ST_DONE;
                end else begin
                    state <= ST_SEARCH;
                end
                ST_SEARCH: if (!in_range) begin
                    out_invalid <= 1'b1;
                    out_temp    <= '0;
                    state       <= ST_DONE;
                end else if (hit) begin
                    base_temp <= temp_lo;
                    state     <= ST_DIV;
                end else if (go_up) begin
                    low <= mid + IDX_W'(1);
                end else begin
                    high <= mid - IDX_W'(1);
                end
                ST_DIV: if (div_done) begin
                    out_temp    <= base_temp + $signed(32'(div_quo));
                    out_invalid <= 1'b0;
                    state       <= ST_DONE;
                end
                ST_DONE: if (out_ready) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Latency monitor: edges spent between acceptance and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (state == ST_IDLE) begin
            lat_cnt <= '0;
        end else if (state != ST_DONE) begin
            lat_cnt <= lat_cnt + 8'd1;
        end
    end

    // R10: a pending result is held steady.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_temp) && $stable(out_invalid));

    // R6, R7, R8: every rejected reading reports zero.
    a_r6_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_invalid |-> out_temp == 0);

    // R4, R5: interpolated results stay inside the table span.
    a_r4_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_invalid |-> (out_temp >= TEMP_MIN) && (out_temp <= TEMP_MAX));

    // R11: an accepted reading closes the input until its result is consumed.
    a_r11_accept_once: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    // R8: search bounds never leave the searchable index range.
    a_r8_search_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SEARCH |-> (low >= IDX_W'(1)) && (high <= IDX_W'(LEN - 1)));

    // R12: result is presented within the latency bound.
    a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lat_cnt <= 8'(LAT_MAX));

endmodule

// File: tb/code_temp_conv_test.sv
`timescale 1ns/1ps
// Directed bench: one rising 12-bit converter (uut) and one falling 10-bit
// converter (uut_dec), driven and sampled on falling clock edges.
module code_temp_conv_test;

    localparam int LAT_MAX = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        sel_dec = 1'b0;
    logic        drv_valid = 1'b0;
    logic        drv_oready = 1'b0;
    logic [15:0] drv_code = '0;

    logic               ir_i, ov_i, inv_i, ir_d, ov_d, inv_d;
    logic signed [31:0] t_i, t_d;
    logic               mon_ready, mon_ovalid, mon_inv;
    logic signed [31:0] mon_temp;

    int n_checks = 0;
    int n_fail = 0;

    code_temp_conv uut (
        .clk(clk), .rst_n(rst_n), .in_valid(drv_valid & ~sel_dec), .in_ready(ir_i),
        .in_code(drv_code), .out_valid(ov_i), .out_ready(drv_oready & ~sel_dec),
        .out_temp(t_i), .out_invalid(inv_i)
    );

    code_temp_conv #(.MASK_BITS(10), .RISING(1'b0), .BASE_CODE(900)) uut_dec (
        .clk(clk), .rst_n(rst_n), .in_valid(drv_valid & sel_dec), .in_ready(ir_d),
        .in_code(drv_code), .out_valid(ov_d), .out_ready(drv_oready & sel_dec),
        .out_temp(t_d), .out_invalid(inv_d)
    );

    assign mon_ready  = sel_dec ? ir_d  : ir_i;
    assign mon_ovalid = sel_dec ? ov_d  : ov_i;
    assign mon_inv    = sel_dec ? inv_d : inv_i;
    assign mon_temp   = sel_dec ? t_d   : t_i;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Table of R3 written out for the bench.
    function automatic int bcode(bit dec, int i);
        int k;
        k = i - 1;
        if (!dec) begin
            if (i == 0)  return 0;
            if (i == 35) return 4095;
            return 300 + 9 * k + k / 3;
        end
        if (i == 0)  return 1023;
        if (i == 35) return bcode(1'b1, 34) - 9;
        return 900 - (9 * k + k / 3);
    endfunction

    function automatic int btemp(int i);
        if (i == 0)  return -40000;
        if (i == 35) return 125000;
        return -40000 + 5000 * (i - 1);
    endfunction

    // Expected result per R2, R4..R8, found by a linear scan.
    task automatic model(input bit dec, input int code, output bit inv, output int temp);
        int c;
        c = code & (dec ? 1023 : 4095);
        inv = 1'b1;
        temp = 0;
        if (!dec && c < bcode(1'b0, 1)) return;
        if (dec && c < bcode(1'b1, 35)) return;
        for (int m = 1; m < 36; m++) begin
            int a;
            int b;
            bit hit;
            a = bcode(dec, m - 1);
            b = bcode(dec, m);
            hit = dec ? (b <= c && c < a) : (a < c && c <= b);
            if (hit) begin
                inv = 1'b0;
                temp = btemp(m - 1) + ((btemp(m) - btemp(m - 1)) * (dec ? a - c : c - a))
                       / (dec ? a - b : b - a);
                return;
            end
        end
    endtask

    // One full conversion with latency, value, hold and consume checks.
    task automatic convert(input bit dec, input logic [15:0] code, input string req);
        bit e_inv;
        int e_t;
        int lat;
        model(dec, int'(code), e_inv, e_t);
        @(negedge clk);
        sel_dec = dec;
        drv_code = code;
        drv_valid = 1'b1;
        chk(mon_ready == 1'b1, {req, " R11 ready before accept"}, mon_ready, 1);
        @(negedge clk);
        drv_valid = 1'b0;
        lat = 0;
        while (!mon_ovalid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk(lat <= LAT_MAX, {req, " R12 latency"}, lat, LAT_MAX);
        chk(mon_inv == e_inv, {req, " invalid flag"}, mon_inv, e_inv);
        chk(mon_temp == e_t, {req, " temperature"}, mon_temp, e_t);
        @(negedge clk);
        @(negedge clk);
        chk(mon_ovalid && mon_temp == e_t && mon_inv == e_inv, {req, " R10 hold"}, mon_temp, e_t);
        drv_oready = 1'b1;
        @(negedge clk);
        drv_oready = 1'b0;
        chk(!mon_ovalid && mon_ready, {req, " R11 consumed"}, mon_ovalid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ir_i && ir_d, "R1 in_ready after reset", ir_i & ir_d, 1);
        chk(!ov_i && !ov_d, "R1 out_valid after reset", ov_i | ov_d, 0);
    endtask

    task automatic t_mask();
        convert(1'b0, 16'hF12C, "R2 rising upper bits");
        convert(1'b0, 16'h8000 | 16'd450, "R2 rising mid code");
        convert(1'b1, 16'hFC00 | 16'd700, "R2 falling upper bits");
    endtask

    task automatic t_table_points();
        convert(1'b0, 16'(bcode(1'b0, 1)), "R3 R9 rising first entry");
        convert(1'b0, 16'(bcode(1'b0, 10)), "R3 R9 rising entry 10");
        convert(1'b0, 16'(bcode(1'b0, 34)), "R3 R9 rising entry 34");
        convert(1'b0, 16'd1000, "R9 rising top band");
        convert(1'b0, 16'd4095, "R9 rising top code");
        convert(1'b1, 16'(bcode(1'b1, 20)), "R3 R9 falling entry 20");
    endtask

    task automatic t_interp_rising();
        convert(1'b0, 16'd301, "R4 interp 301");
        convert(1'b0, 16'd305, "R4 interp 305");
        convert(1'b0, 16'd350, "R4 interp 350");
        convert(1'b0, 16'd477, "R4 interp 477");
        convert(1'b0, 16'd607, "R4 interp 607");
    endtask

    task automatic t_interp_falling();
        convert(1'b1, 16'd899, "R5 interp 899");
        convert(1'b1, 16'd850, "R5 interp 850");
        convert(1'b1, 16'd600, "R5 interp 600");
        convert(1'b1, 16'd590, "R9 falling band 590");
        convert(1'b1, 16'd583, "R9 falling band floor");
    endtask

    task automatic t_reject();
        convert(1'b0, 16'd0, "R6 rising code 0");
        convert(1'b0, 16'd299, "R6 rising below floor");
        convert(1'b0, 16'h1005, "R6 rising masked low");
        convert(1'b1, 16'd582, "R7 falling below floor");
        convert(1'b1, 16'd0, "R7 falling code 0");
        convert(1'b1, 16'd1023, "R8 falling top code");
        convert(1'b1, 16'hFFFF, "R8 falling masked top");
    endtask

    // R11: stimulus while busy changes nothing and yields no second result.
    task automatic t_busy_ignore();
        bit e_inv;
        int e_t;
        int lat;
        model(1'b0, 400, e_inv, e_t);
        @(negedge clk);
        sel_dec = 1'b0;
        drv_code = 16'd400;
        drv_valid = 1'b1;
        @(negedge clk);
        drv_code = 16'd500;
        for (int i = 0; i < 5; i++) begin
            chk(!mon_ready, "R11 in_ready low while busy", mon_ready, 0);
            @(negedge clk);
        end
        lat = 5;
        while (!mon_ovalid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        drv_valid = 1'b0;
        chk(lat <= LAT_MAX, "R12 latency busy case", lat, LAT_MAX);
        chk(mon_temp == e_t && !mon_inv, "R11 result of first code", mon_temp, e_t);
        drv_oready = 1'b1;
        @(negedge clk);
        drv_oready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(!mon_ovalid, "R11 no second result", mon_ovalid, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_mask();
        t_table_points();
        t_interp_rising();
        t_interp_falling();
        t_reject();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule